// File: doc/BRIEF.md
# Watchdog Timer with Level or Pulse Reset Output

This block is a hardware watchdog controlled through a byte-wide register file. Software loads an 8-bit count, chooses whether that count is in seconds or minutes, and enables the timer. The count steps down once per time unit. The time unit is derived from an external 1 ms tick by a prescaler held inside the block.

When the count reaches zero, the block sets a sticky timeout flag and drives an active-low reset output. That output is either a level, which holds until the watchdog is disabled or reloaded, or a pulse of one of four widths. Rewriting the count register is the keepalive action. It reloads the count, releases a pending reset and restarts the prescaler, so each keepalive always grants a full first unit.

Three registers are decoded: an output-control register at 0xF0, a timer-control register at 0xF5 and the count register at 0xF6. Reads are combinational. The count register reads back the live count.

Top module: `wdog_pulse_timer`

## Requirements
- R1: After reset, reads of 0xF0, 0xF5 and 0xF6 return 0x00 and `wdt_rst_n` is high.
- R2: A write to 0xF6 loads the count, which reads back at 0xF6. In second units (0xF5 bit 3 = 0) the count drops by one after every TICKS_PER_SEC ms ticks.
- R3: With 0xF5 bit 3 = 1 (minute units), the count drops by one after every TICKS_PER_SEC*SECS_PER_MIN ms ticks.
- R4: In level mode (0xF5 bit 4 = 0), when the count reaches zero with 0xF0 bit 7 set, `wdt_rst_n` goes low. It stays low through further ticks until 0xF6 is written again.
- R5: In pulse mode (0xF5 bit 4 = 1), 0xF5 bits 1:0 select a width of PW0, PW1, PW2 or PW3 ms ticks for codes 0 to 3. `wdt_rst_n` is low for exactly that many ticks after expiry and then returns high.
- R6: Expiry sets 0xF5 bit 6. The bit stays set when 0xF5 is written with bit 6 = 0, and it is cleared by writing 0xF5 with bit 6 = 1.
- R7: While 0xF0 bit 7 is clear, `wdt_rst_n` stays high even on expiry, while the timeout flag is still set.
- R8: The count changes only while both `dev_en` and 0xF5 bit 5 are set. Otherwise it holds.
- R9: Clearing 0xF5 bit 5 releases a low `wdt_rst_n` on the next clock.
- R10: A count of zero written while enabled causes no expiry. The timer idles at zero with the output high.
- R11: A write to 0xF6 restarts the prescaler, so the next decrement comes a full unit after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| dev_en | input | 1 | Logical-device enable; gates counting |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write register offset |
| wr_data | input | 8 | Write data |
| rd_addr | input | 8 | Read register offset |
| rd_data | output | 8 | Combinational read data |
| wdt_rst_n | output | 1 | Active-low reset output |

## Verification
The bench targets the points where a watchdog most easily misbehaves:
- A prescaler that is not restarted by a keepalive would expire part of a unit early.
- A level output that auto-releases, or a pulse that is one tick too long or too short, shows up in tick-by-tick sampling around the release point.
- A zero count that fires at once, or a status bit that clears on any write to its register, would be caught by the idle-at-zero and sticky-flag scenarios.
- Counting while only one of the two enables is set would move the read-back count.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam logic [7:0] OFS_OUTCTL = 8'hF0;
   localparam logic [7:0] OFS_TIMCTL = 8'hF5;
   localparam logic [7:0] OFS_COUNT  = 8'hF6;

   localparam int B_DRV_EN  = 7;
   localparam int B_STATUS  = 6;
   localparam int B_ENABLE  = 5;
   localparam int B_PULSE   = 4;
   localparam int B_MINUTES = 3;
endpackage

// File: rtl/wdt_unit_prescaler.sv
module wdt_unit_prescaler #(
   parameter int TICKS_PER_SEC = 1000,
   parameter int SECS_PER_MIN  = 60
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart_i,
   input  logic ms_tick_i,
   input  logic minutes_i,
   output logic unit_tick_o
);
   localparam int MSW = $clog2(TICKS_PER_SEC + 1);
   localparam logic [MSW-1:0] MS_LAST = MSW'(TICKS_PER_SEC - 1);

   initial assert (TICKS_PER_SEC >= 1) else $error("TICKS_PER_SEC must be at least 1");
   initial assert (SECS_PER_MIN >= 1)  else $error("SECS_PER_MIN must be at least 1");

   logic [MSW-1:0] ms_q;
   logic           sec_tick;
   logic           min_tick;

   assign sec_tick = ms_tick_i && (ms_q == MS_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ms_q <= '0;
      else if (restart_i) ms_q <= '0;
      else if (ms_tick_i) ms_q <= sec_tick ? '0 : ms_q + 1'b1;
   end

   generate
      if (SECS_PER_MIN > 1) begin : g_min_stage
         localparam int SW = $clog2(SECS_PER_MIN + 1);
         localparam logic [SW-1:0] SEC_LAST = SW'(SECS_PER_MIN - 1);
         logic [SW-1:0] sec_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         sec_q <= '0;
            else if (restart_i) sec_q <= '0;
            else if (sec_tick)  sec_q <= (sec_q == SEC_LAST) ? '0 : sec_q + 1'b1;
         end
         assign min_tick = sec_tick && (sec_q == SEC_LAST);
      end else begin : g_min_direct
         assign min_tick = sec_tick;
      end
   endgenerate

   assign unit_tick_o = minutes_i ? min_tick : sec_tick;
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          active_i,
   input  logic          unit_tick_i,
   input  logic          load_i,
   input  logic [CW-1:0] load_val_i,
   output logic [CW-1:0] count_o,
   output logic          expire_o
);
   initial assert (CW >= 1) else $error("CW must be at least 1");

   logic [CW-1:0] count_q;
   logic          step;

   assign step     = active_i && unit_tick_i && (count_q != '0) && !load_i;
   assign expire_o = step && (count_q == CW'(1));
   assign count_o  = count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     count_q <= '0;
      else if (load_i) count_q <= load_val_i;
      else if (step)  count_q <= count_q - 1'b1;
   end

   AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_i && !load_i) |=> $stable(count_q)); // R8
   AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (count_q == '0 && !load_i) |=> (count_q == '0)); // R10
   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && count_q != '0) |=>
      (count_q == $past(count_q) || count_q == $past(count_q) - 1'b1)); // R2
endmodule

// File: rtl/wdt_reset_driver.sv
module wdt_reset_driver #(
   parameter int PW0 = 1,
   parameter int PW1 = 25,
   parameter int PW2 = 125,
   parameter int PW3 = 5000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       active_i,
   input  logic       drv_en_i,
   input  logic       release_i,
   input  logic       expire_i,
   input  logic       ms_tick_i,
   input  logic       pulse_mode_i,
   input  logic [1:0] pw_sel_i,
   output logic       rst_n_o
);
   localparam int PWMAX = (PW0 > PW1 ? PW0 : PW1) > (PW2 > PW3 ? PW2 : PW3)
                        ? (PW0 > PW1 ? PW0 : PW1) : (PW2 > PW3 ? PW2 : PW3);
   localparam int PCW = $clog2(PWMAX + 1);

   initial assert (PW0 >= 1 && PW1 >= 1 && PW2 >= 1 && PW3 >= 1)
      else $error("pulse widths must be at least 1");

   logic           low_q, low_d;
   logic [PCW-1:0] pcnt_q, pcnt_d;
   logic [PCW-1:0] width;
   logic           out_q;

   always_comb begin
      case (pw_sel_i)
         2'd0:    width = PCW'(PW0);
         2'd1:    width = PCW'(PW1);
         2'd2:    width = PCW'(PW2);
         default: width = PCW'(PW3);
      endcase
   end

   always_comb begin
      low_d  = low_q;
      pcnt_d = pcnt_q;
      if (!active_i || release_i) begin
         low_d  = 1'b0;
         pcnt_d = '0;
      end else if (expire_i) begin
         low_d  = 1'b1;
         pcnt_d = width;
      end else if (low_q && pulse_mode_i && ms_tick_i) begin
         pcnt_d = (pcnt_q == '0) ? '0 : pcnt_q - 1'b1;
         if (pcnt_q <= PCW'(1)) low_d = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_q  <= 1'b0;
         pcnt_q <= '0;
         out_q  <= 1'b1;
      end else begin
         low_q  <= low_d;
         pcnt_q <= pcnt_d;
         out_q  <= !(low_d && drv_en_i && active_i);
      end
   end

   assign rst_n_o = out_q;

   AST_RELEASE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !active_i |=> rst_n_o); // R9
   AST_NO_DRIVE_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      !drv_en_i |=> rst_n_o); // R7
   AST_KEEPALIVE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      release_i |=> rst_n_o); // R4
endmodule

// File: rtl/wdog_pulse_timer.sv
module wdog_pulse_timer #(
   parameter int TICKS_PER_SEC = 1000,
   parameter int SECS_PER_MIN  = 60,
   parameter int PW0 = 1,
   parameter int PW1 = 25,
   parameter int PW2 = 125,
   parameter int PW3 = 5000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ms_tick,
   input  logic       dev_en,
   input  logic       wr_en,
   input  logic [7:0] wr_addr,
   input  logic [7:0] wr_data,
   input  logic [7:0] rd_addr,
   output logic [7:0] rd_data,
   output logic       wdt_rst_n
);
   import wdt_pkg::*;

   logic       drv_en_q, sts_q, en_q, pulse_q, min_q;
   logic [1:0] pw_q;
   logic       wr_out, wr_tim, wr_cnt;
   logic       active, unit_tick, expire;
   logic [7:0] count;

   assign wr_out = wr_en && (wr_addr == OFS_OUTCTL);
   assign wr_tim = wr_en && (wr_addr == OFS_TIMCTL);
   assign wr_cnt = wr_en && (wr_addr == OFS_COUNT);
   assign active = dev_en && en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drv_en_q <= 1'b0;
         sts_q    <= 1'b0;
         en_q     <= 1'b0;
         pulse_q  <= 1'b0;
         min_q    <= 1'b0;
         pw_q     <= 2'd0;
      end else begin
         if (wr_out) drv_en_q <= wr_data[B_DRV_EN];
         if (wr_tim) begin
            en_q    <= wr_data[B_ENABLE];
            pulse_q <= wr_data[B_PULSE];
            min_q   <= wr_data[B_MINUTES];
            pw_q    <= wr_data[1:0];
         end
         if (expire)                           sts_q <= 1'b1;
         else if (wr_tim && wr_data[B_STATUS]) sts_q <= 1'b0;
      end
   end

   always_comb begin
      case (rd_addr)
         OFS_OUTCTL: rd_data = {drv_en_q, 7'b0};
         OFS_TIMCTL: rd_data = {1'b0, sts_q, en_q, pulse_q, min_q, 1'b0, pw_q};
         OFS_COUNT:  rd_data = count;
         default:    rd_data = 8'h00;
      endcase
   end

   wdt_unit_prescaler #(
      .TICKS_PER_SEC(TICKS_PER_SEC),
      .SECS_PER_MIN (SECS_PER_MIN)
   ) u_presc (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart_i  (wr_cnt || !active),
      .ms_tick_i  (ms_tick),
      .minutes_i  (min_q),
      .unit_tick_o(unit_tick)
   );

   wdt_countdown #(.CW(8)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .active_i   (active),
      .unit_tick_i(unit_tick),
      .load_i     (wr_cnt),
      .load_val_i (wr_data),
      .count_o    (count),
      .expire_o   (expire)
   );

   wdt_reset_driver #(
      .PW0(PW0), .PW1(PW1), .PW2(PW2), .PW3(PW3)
   ) u_drv (
      .clk         (clk),
      .rst_n       (rst_n),
      .active_i    (active),
      .drv_en_i    (drv_en_q),
      .release_i   (wr_cnt),
      .expire_i    (expire),
      .ms_tick_i   (ms_tick),
      .pulse_mode_i(pulse_q),
      .pw_sel_i    (pw_q),
      .rst_n_o     (wdt_rst_n)
   );

   AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_q && !(wr_tim && wr_data[B_STATUS])) |=> sts_q); // R6
   AST_EXPIRE_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> sts_q); // R6
endmodule

// File: tb/wdog_pulse_timer_tb_top.sv
`timescale 1ns/1ps
module wdog_pulse_timer_tb_top;
   localparam int TPS = 4;
   localparam int SPM = 3;
   localparam int PW[4] = '{1, 3, 5, 8};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ms_tick = 1'b0;
   logic       dev_en = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_addr = 8'h00;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_addr = 8'h00;
   logic [7:0] rd_data;
   logic       wdt_rst_n;

   int n_checks = 0;
   int n_fails  = 0;
   int cycles   = 0;

   always #2 clk = ~clk;

   wdog_pulse_timer #(
      .TICKS_PER_SEC(TPS), .SECS_PER_MIN(SPM),
      .PW0(PW[0]), .PW1(PW[1]), .PW2(PW[2]), .PW3(PW[3])
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .dev_en(dev_en),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .wdt_rst_n(wdt_rst_n)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         n_checks = n_checks + 1;
         n_fails  = n_fails + 1;
         $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
         $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
         $finish;
      end
   end

   task automatic check(string req, int act, int exp);
      n_checks = n_checks + 1;
      if (act != exp) begin
         n_fails = n_fails + 1;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic rd(logic [7:0] a, output logic [7:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         ms_tick = 1'b1;
         @(negedge clk);
         ms_tick = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic check_reg(string req, logic [7:0] a, logic [7:0] exp);
      logic [7:0] d;
      rd(a, d);
      check(req, int'(d), int'(exp));
   endtask

   task automatic check_out(string req, logic exp);
      check(req, int'(wdt_rst_n), int'(exp));
   endtask

   task automatic t_reset();
      check_reg("R1 outctl", 8'hF0, 8'h00);
      check_reg("R1 timctl", 8'hF5, 8'h00);
      check_reg("R1 count", 8'hF6, 8'h00);
      check_out("R1 output", 1'b1);
   endtask

   task automatic t_seconds_level();
      dev_en = 1'b1;
      wr(8'hF0, 8'h80);
      wr(8'hF5, 8'h20);
      wr(8'hF6, 8'd3);
      check_reg("R2 load", 8'hF6, 8'd3);
      ticks(TPS - 1);
      check_reg("R2 before unit", 8'hF6, 8'd3);
      ticks(1);
      check_reg("R2 one unit", 8'hF6, 8'd2);
      ticks(2 * TPS - 1);
      check_reg("R2 last unit", 8'hF6, 8'd1);
      check_out("R4 before expiry", 1'b1);
      ticks(1);
      check_out("R4 expiry low", 1'b0);
      check_reg("R6 status set", 8'hF5, 8'h60);
      ticks(8);
      check_out("R4 level held", 1'b0);
      check_reg("R4 count stays zero", 8'hF6, 8'h00);
      wr(8'hF6, 8'd2);
      check_out("R4 keepalive release", 1'b1);
      wr(8'hF5, 8'h20);
      check_reg("R6 sticky on write 0", 8'hF5, 8'h60);
      wr(8'hF5, 8'h60);
      check_reg("R6 write 1 clears", 8'hF5, 8'h20);
   endtask

   task automatic t_keepalive();
      wr(8'hF6, 8'd1);
      ticks(TPS - 1);
      wr(8'hF6, 8'd1);
      ticks(TPS - 1);
      check_out("R11 full unit after keepalive", 1'b1);
      check_reg("R11 count kept", 8'hF6, 8'd1);
      ticks(1);
      check_out("R11 expires after full unit", 1'b0);
      wr(8'hF5, 8'h60);
      wr(8'hF6, 8'd0);
      check_out("R10 zero write releases", 1'b1);
      ticks(5 * TPS);
      check_out("R10 idle at zero", 1'b1);
      check_reg("R10 no status", 8'hF5, 8'h20);
   endtask

   task automatic t_minutes();
      wr(8'hF5, 8'h28);
      wr(8'hF6, 8'd2);
      ticks(TPS * SPM - 1);
      check_reg("R3 before minute", 8'hF6, 8'd2);
      ticks(1);
      check_reg("R3 one minute", 8'hF6, 8'd1);
      ticks(TPS * SPM - 1);
      check_out("R3 before expiry", 1'b1);
      ticks(1);
      check_out("R3 expiry", 1'b0);
      wr(8'hF5, 8'h08);
      check_out("R9 disable releases", 1'b1);
      check_reg("R9 status kept", 8'hF5, 8'h48);
   endtask

   task automatic t_gating();
      wr(8'hF5, 8'h60);
      wr(8'hF6, 8'd2);
      dev_en = 1'b0;
      ticks(5 * TPS);
      check_reg("R8 device off holds", 8'hF6, 8'd2);
      check_out("R8 device off output", 1'b1);
      dev_en = 1'b1;
      wr(8'hF5, 8'h00);
      ticks(5 * TPS);
      check_reg("R8 enable off holds", 8'hF6, 8'd2);
      wr(8'hF5, 8'h20);
      ticks(2 * TPS - 1);
      check_out("R8 both on counts", 1'b1);
      ticks(1);
      check_out("R8 expiry when both on", 1'b0);
      wr(8'hF5, 8'h40);
      check_out("R9 release", 1'b1);
   endtask

   task automatic t_pulse();
      for (int code = 0; code < 4; code++) begin
         wr(8'hF5, 8'h70 | 8'(code));
         wr(8'hF6, 8'd1);
         ticks(TPS - 1);
         check_out("R5 before expiry", 1'b1);
         ticks(1);
         check_out("R5 pulse starts", 1'b0);
         if (PW[code] > 1) begin
            ticks(PW[code] - 1);
            check_out("R5 pulse still low", 1'b0);
         end
         ticks(1);
         check_out("R5 pulse ends", 1'b1);
         check_reg("R6 pulse status", 8'hF5, 8'h70 | 8'(code));
         wr(8'hF5, 8'h40);
      end
   endtask

   task automatic t_no_drive();
      wr(8'hF0, 8'h00);
      wr(8'hF5, 8'h60);
      wr(8'hF6, 8'd1);
      ticks(TPS);
      check_out("R7 output stays high", 1'b1);
      check_reg("R7 status still set", 8'hF5, 8'h60);
      wr(8'hF0, 8'h80);
      check_reg("R7 outctl readback", 8'hF0, 8'h80);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_seconds_level();
      t_keepalive();
      t_minutes();
      t_gating();
      t_pulse();
      t_no_drive();
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
   end
endmodule